// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block is the receive half of an asynchronous serial port. A divider elsewhere in the chip delivers a one-cycle tick at five times the bit rate. The receiver passes the serial line through a synchroniser and waits for a falling edge. It then confirms the start bit at the middle of its slot and shifts in a character of 7 or 8 bits, LSB or MSB first. An optional even or odd parity bit and one or two stop bits follow.

A finished character goes into a holding register and raises a full flag, which stays set until the consumer acknowledges the read. Parity, framing and overrun errors are kept as sticky flags. A clear command drops them and also throws the receive state machine back to idle, so that the next falling edge starts a new frame. The enable input forces the receiver to idle.

One behaviour keeps the receiver locked to a line that is stuck low. If the stop bit is sampled low and the line is still low when the stop slot ends, the next slot counts as a start bit even though no falling edge came before it. A bus held dominant therefore yields a steady stream of framing errors. A bus-idle output shows whether a frame is in progress.

Top module: `uart_rx_core`

## Requirements
- R1: With `len8`=1 eight data bits are received; with `len8`=0 seven bits are received and placed in `rx_data[6:0]` with `rx_data[7]`=0. With `msb_first`=0 the first data bit on the line is bit 0; with `msb_first`=1 it is the top bit of the character.
- R2: With `par_en`=1 a parity bit follows the data. `par_odd`=0 asks for an even number of ones across data and parity, and `par_odd`=1 asks for an odd number. A mismatch sets `err_parity`. With `par_en`=0 no parity slot exists and `err_parity` is never set.
- R3: With `stop2`=0 there is one stop slot and with `stop2`=1 there are two. A stop slot sampled low sets `err_frame`.
- R4: Each bit slot lasts five `os_tick` pulses, and the line is sampled once per slot, at its middle tick.
- R5: A start bit is accepted only if the line is still low at the middle of the start slot. Otherwise the receiver returns to idle and writes nothing.
- R6: When the last stop slot is sampled, the character is written to `rx_data` and `rx_full` goes to 1. A one-cycle `rd_ack` clears `rx_full`.
- R7: If a character completes while `rx_full` is 1 and no `rd_ack` arrives in that cycle, `err_overrun` is set and the new character replaces the old one.
- R8: The error flags stay set until `clr_err` arrives. `clr_err` clears all three flags and returns the receiver to idle, dropping any partial frame. The next falling edge then starts a new frame.
- R9: If the last stop slot is sampled low and the line is still low at the end of that slot, the next slot is treated as a start bit with no falling edge.
- R10: With `rx_en`=0 the receiver is held idle. After `rx_en` returns to 1, reception waits for a true falling edge.
- R11: `bus_idle` is 1 when no frame is being received and 0 from start detection until the frame ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | One-cycle pulse at five times the bit rate |
| rx_in | input | 1 | Serial line, idle high, asynchronous |
| rx_en | input | 1 | Receive enable |
| len8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| par_en | input | 1 | Parity slot present |
| par_odd | input | 1 | 1: odd parity, 0: even parity |
| stop2 | input | 1 | 1: two stop slots, 0: one |
| msb_first | input | 1 | 1: MSB first, 0: LSB first |
| clr_err | input | 1 | Strobe: clear error flags and reset the receive state machine |
| rd_ack | input | 1 | Strobe: holding register has been read |
| rx_data | output | 8 | Last received character |
| rx_full | output | 1 | Holding register holds an unread character |
| err_parity | output | 1 | Sticky parity error |
| err_frame | output | 1 | Sticky framing error |
| err_overrun | output | 1 | Sticky overrun error |
| bus_idle | output | 1 | No frame in progress |

## Verification
The hardest case to reach from the ports is a start with no falling edge after a low stop bit. To get there the line must go low for a whole frame and then stay low. The stimulus sends a character whose stop bit is low, keeps the line low for more than a frame, and reads the holding register in between. A second character of all zeros must then arrive with no edge at all. The same stimulus is repeated with the enable toggled in the low stretch, and this time nothing may arrive. Clear-while-receiving is reached by cutting a frame off after a few data bits, and a short low pulse is used to check that a glitch is rejected.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP,
    RX_BRK
  } rx_state_e;

  // Insert one sampled bit into the assembly register.
  function automatic logic [7:0] shift_in(input logic [7:0] sh, input logic b,
                                          input logic msb);
    return msb ? {sh[6:0], b} : {b, sh[7:1]};
  endfunction

  // Align the assembled bits into a right-justified character.
  function automatic logic [7:0] finish_word(input logic [7:0] sh, input logic len8,
                                             input logic msb);
    if (len8) return sh;
    if (msb)  return {1'b0, sh[6:0]};
    return {1'b0, sh[7:1]};
  endfunction

  // 1 when data plus parity bit disagree with the selected sense.
  function automatic logic parity_bad(input logic [7:0] data, input logic pbit,
                                      input logic odd);
    return (^data) ^ pbit ^ ~odd ^ 1'b1;
  endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b1;
        else if (i == 0) chain[i] <= din;
        else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b1;
    else prev <= dout;
  end

  assign fall = prev & ~dout;

endmodule

// File: rtl/uart_rx_framer.sv
module uart_rx_framer
  import uart_rx_pkg::*;
#(
  parameter int OS_RATE = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd,
  input  logic       fall,
  input  logic       en,
  input  logic       clr,
  input  logic       len8,
  input  logic       par_en,
  input  logic       odd,
  input  logic       stop2,
  input  logic       msb,
  output logic       busy,
  output logic       commit,
  output logic [7:0] word,
  output logic       par_err,
  output logic       stop_err
);
  localparam int PW = $clog2(OS_RATE);
  localparam logic [PW-1:0] MID  = PW'(OS_RATE / 2);
  localparam logic [PW-1:0] LAST = PW'(OS_RATE - 1);

  rx_state_e     state;
  logic [PW-1:0] phase;
  logic [3:0]    bitcnt;
  logic [7:0]    sh;
  logic          pbad, sbad, stop_idx;

  logic       mid_hit, slot_end, last_stop;
  logic [3:0] nbits;

  assign mid_hit   = tick && (phase == MID);
  assign slot_end  = tick && (phase == LAST);
  assign nbits     = len8 ? 4'd8 : 4'd7;
  assign last_stop = (stop_idx == stop2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= RX_IDLE;
      phase    <= '0;
      bitcnt   <= '0;
      sh       <= '0;
      pbad     <= 1'b0;
      sbad     <= 1'b0;
      stop_idx <= 1'b0;
    end else if (clr || !en) begin
      state <= RX_IDLE;
      phase <= '0;
    end else if (state == RX_IDLE) begin
      if (fall) begin
        state <= RX_START;
        phase <= '0;
      end
    end else begin
      if (tick) phase <= slot_end ? '0 : phase + 1'b1;
      unique case (state)
        RX_START: begin
          if (mid_hit && rxd) state <= RX_IDLE;
          else if (slot_end) begin
            state  <= RX_DATA;
            bitcnt <= '0;
            pbad   <= 1'b0;
            sbad   <= 1'b0;
          end
        end
        RX_DATA: begin
          if (mid_hit) begin
            sh     <= shift_in(sh, rxd, msb);
            bitcnt <= bitcnt + 1'b1;
          end
          if (slot_end && bitcnt == nbits) begin
            state    <= par_en ? RX_PAR : RX_STOP;
            stop_idx <= 1'b0;
          end
        end
        RX_PAR: begin
          if (mid_hit) pbad <= parity_bad(finish_word(sh, len8, msb), rxd, odd);
          if (slot_end) state <= RX_STOP;
        end
        RX_STOP: begin
          if (mid_hit) begin
            if (!rxd) sbad <= 1'b1;
            if (last_stop) state <= rxd ? RX_IDLE : RX_BRK;
          end else if (slot_end) begin
            stop_idx <= 1'b1;
          end
        end
        RX_BRK: begin
          // Line still low at the slot boundary: this slot is a start bit.
          if (slot_end) state <= rxd ? RX_IDLE : RX_START;
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  assign busy     = (state != RX_IDLE);
  assign commit   = (state == RX_STOP) && mid_hit && last_stop && en && !clr;
  assign word     = finish_word(sh, len8, msb);
  assign par_err  = par_en && pbad;
  assign stop_err = sbad || !rxd;

  // R10: leaving idle always follows a detected falling edge
  assert_start_on_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(fall));

  // R10: a low enable parks the receiver
  assert_disable_idles_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !busy);

  // R8: the clear command abandons any frame in progress
  assert_clear_idles_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !busy);

  // R4: the character is taken on a tick only
  assert_commit_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> tick);

endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       commit,
  input  logic [7:0] word,
  input  logic       par_err,
  input  logic       stop_err,
  input  logic       rd,
  input  logic       clr,
  output logic [7:0] data,
  output logic       full,
  output logic       pe,
  output logic       fe,
  output logic       ore
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data <= '0;
      full <= 1'b0;
      pe   <= 1'b0;
      fe   <= 1'b0;
      ore  <= 1'b0;
    end else begin
      if (commit) data <= word;

      if (commit) full <= 1'b1;
      else if (rd) full <= 1'b0;

      if (clr) begin
        pe  <= 1'b0;
        fe  <= 1'b0;
        ore <= 1'b0;
      end else if (commit) begin
        if (par_err)     pe  <= 1'b1;
        if (stop_err)    fe  <= 1'b1;
        if (full && !rd) ore <= 1'b1;
      end
    end
  end

  // R6: a finished character marks the holding register full
  assert_commit_sets_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> full);

  // R6: an acknowledged read empties it
  assert_read_clears_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !commit) |=> !full);

  // R7: unread data overwritten raises overrun
  assert_overrun_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && full && !rd) |=> ore);

  // R8: clear leaves no error flag standing
  assert_clear_errors_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !(pe || fe || ore));

  // R8: error flags only fall on a clear
  assert_sticky_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fe && !clr) |=> fe);

endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core #(
  parameter int OS_RATE     = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       os_tick,
  input  logic       rx_in,
  input  logic       rx_en,
  input  logic       len8,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       stop2,
  input  logic       msb_first,
  input  logic       clr_err,
  input  logic       rd_ack,
  output logic [7:0] rx_data,
  output logic       rx_full,
  output logic       err_parity,
  output logic       err_frame,
  output logic       err_overrun,
  output logic       bus_idle
);
  logic       rxd, fall_evt, busy, commit_evt, par_err, stop_err;
  logic [7:0] word;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rx_in), .dout(rxd), .fall(fall_evt)
  );

  uart_rx_framer #(.OS_RATE(OS_RATE)) u_framer (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .rxd(rxd), .fall(fall_evt),
    .en(rx_en), .clr(clr_err), .len8(len8), .par_en(par_en), .odd(par_odd),
    .stop2(stop2), .msb(msb_first), .busy(busy), .commit(commit_evt),
    .word(word), .par_err(par_err), .stop_err(stop_err)
  );

  uart_rx_hold u_hold (
    .clk(clk), .rst_n(rst_n), .commit(commit_evt), .word(word),
    .par_err(par_err), .stop_err(stop_err), .rd(rd_ack), .clr(clr_err),
    .data(rx_data), .full(rx_full), .pe(err_parity), .fe(err_frame),
    .ore(err_overrun)
  );

  assign bus_idle = !busy;

  // R11: a character can only complete while a frame is in progress
  assert_busy_at_commit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |-> !bus_idle);

endmodule

// File: tb/uart_rx_core_tb.sv
module uart_rx_core_tb;
  localparam int BITCLK = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic os_tick = 1'b0;
  logic [1:0] tdiv = 2'd0;
  logic rx_in = 1'b1, rx_en = 1'b0;
  logic len8 = 1'b1, par_en = 1'b0, par_odd = 1'b0, stop2 = 1'b0, msb_first = 1'b0;
  logic clr_err = 1'b0, rd_ack = 1'b0;
  logic [7:0] rx_data;
  logic rx_full, err_parity, err_frame, err_overrun, bus_idle;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  always @(negedge clk) begin
    tdiv    <= tdiv + 2'd1;
    os_tick <= (tdiv == 2'd3);
  end

  uart_rx_core u_dut (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_in(rx_in), .rx_en(rx_en),
    .len8(len8), .par_en(par_en), .par_odd(par_odd), .stop2(stop2),
    .msb_first(msb_first), .clr_err(clr_err), .rd_ack(rd_ack),
    .rx_data(rx_data), .rx_full(rx_full), .err_parity(err_parity),
    .err_frame(err_frame), .err_overrun(err_overrun), .bus_idle(bus_idle)
  );

  // fields: data[14:7] len8[6] par_en[5] odd[4] stop2[3] msb[2] bad_par[1] bad_stop[0]
  localparam logic [14:0] VECS [8] = '{
    {8'hA5, 7'b1000000},
    {8'h3C, 7'b1100100},
    {8'hD3, 7'b0110100},
    {8'h81, 7'b1111000},
    {8'h5A, 7'b1100010},
    {8'h96, 7'b0001001},
    {8'hFF, 7'b1100100},
    {8'h00, 7'b0110000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_bits(input int n);
    repeat (n * BITCLK) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    rx_in = b;
    repeat (BITCLK) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic l8, input logic pe_on,
                            input logic odd, input logic s2, input logic msb,
                            input logic bpar, input logic bstop);
    int n;
    logic [7:0] m;
    n = l8 ? 8 : 7;
    m = l8 ? d : (d & 8'h7F);
    send_bit(1'b0);
    for (int i = 0; i < n; i++) send_bit(msb ? m[n-1-i] : m[i]);
    if (pe_on) send_bit((^m) ^ odd ^ bpar);
    send_bit(!bstop);
    if (s2) send_bit(!bstop);
  endtask

  task automatic pulse_rd();
    rd_ack = 1'b1;
    @(negedge clk);
    rd_ack = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_clr();
    clr_err = 1'b1;
    @(negedge clk);
    clr_err = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 reset idle", bus_idle, 1);
    chk("R6 reset empty", rx_full, 0);
    chk("R8 reset no errors", {err_parity, err_frame, err_overrun}, 0);
    rx_en = 1'b1;
    wait_bits(2);

    // Table walk: formats, orders, parity senses, stop lengths, error injection
    foreach (VECS[k]) begin
      logic [14:0] v;
      logic [7:0] expd;
      v = VECS[k];
      len8 = v[6]; par_en = v[5]; par_odd = v[4]; stop2 = v[3]; msb_first = v[2];
      wait_bits(1);
      send_frame(v[14:7], v[6], v[5], v[4], v[3], v[2], v[1], v[0]);
      rx_in = 1'b1;
      wait_bits(2);
      expd = v[6] ? v[14:7] : (v[14:7] & 8'h7F);
      chk($sformatf("R1 R4 data vec%0d", k), rx_data, expd);
      chk($sformatf("R6 full vec%0d", k), rx_full, 1);
      chk($sformatf("R2 parity flag vec%0d", k), err_parity, v[5] & v[1]);
      chk($sformatf("R3 frame flag vec%0d", k), err_frame, v[0]);
      chk($sformatf("R7 no overrun vec%0d", k), err_overrun, 0);
      chk($sformatf("R11 idle after vec%0d", k), bus_idle, 1);
      pulse_rd();
      chk($sformatf("R6 read clears vec%0d", k), rx_full, 0);
      pulse_clr();
    end

    // R7 overrun and R8 stickiness
    len8 = 1; par_en = 1; par_odd = 0; stop2 = 0; msb_first = 0;
    send_frame(8'h11, 1, 1, 0, 0, 0, 1, 0);
    rx_in = 1'b1; wait_bits(1);
    send_frame(8'h22, 1, 1, 0, 0, 0, 0, 0);
    rx_in = 1'b1; wait_bits(2);
    chk("R7 overrun set", err_overrun, 1);
    chk("R7 newer data kept", rx_data, 8'h22);
    chk("R8 parity error sticky across good frame", err_parity, 1);
    pulse_rd();
    pulse_clr();
    chk("R8 clear drops errors", {err_parity, err_frame, err_overrun}, 0);
    par_en = 0;

    // R5 glitch rejection
    rx_in = 1'b0;
    repeat (4) @(negedge clk);
    rx_in = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11 busy during start check", bus_idle, 0);
    wait_bits(2);
    chk("R5 glitch back to idle", bus_idle, 1);
    chk("R5 glitch writes nothing", rx_full, 0);

    // R8 clear in mid frame, then resync on next edge
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    clr_err = 1'b1;
    @(negedge clk);
    clr_err = 1'b0;
    chk("R8 clear forces idle", bus_idle, 1);
    rx_in = 1'b1;
    wait_bits(10);
    chk("R8 abandoned frame not written", rx_full, 0);
    send_frame(8'h3A, 1, 0, 0, 0, 0, 0, 0);
    rx_in = 1'b1; wait_bits(2);
    chk("R8 resync data", rx_data, 8'h3A);
    chk("R8 resync full", rx_full, 1);
    pulse_rd();

    // R9 dominant bus: low stop then line held low
    send_frame(8'h55, 1, 0, 0, 0, 0, 0, 1);
    rx_in = 1'b0;
    chk("R3 low stop flagged", err_frame, 1);
    chk("R9 first char", rx_data, 8'h55);
    pulse_rd();
    wait_bits(12);
    chk("R9 edgeless start full", rx_full, 1);
    chk("R9 edgeless start data", rx_data, 8'h00);
    chk("R11 busy while dominant", bus_idle, 0);
    rx_in = 1'b1;
    wait_bits(14);
    pulse_rd();
    pulse_clr();

    // R10 enable toggle after framing error waits for a real edge
    send_frame(8'h55, 1, 0, 0, 0, 0, 0, 1);
    rx_in = 1'b0;
    rx_en = 1'b0;
    repeat (3) @(negedge clk);
    rx_en = 1'b1;
    pulse_rd();
    wait_bits(12);
    chk("R10 no edgeless start after re-enable", rx_full, 0);
    chk("R10 idle while low", bus_idle, 1);
    rx_in = 1'b1;
    wait_bits(2);
    chk("R10 rising line starts nothing", rx_full, 0);
    pulse_clr();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule